// File: doc/BRIEF.md
# Multiplexed external bus controller

This block converts single read and write requests from an on-chip master into transfers on an external bus whose address and data travel over the same pins. It runs on an internal clock at twice the bus clock, so one bus clock T equals two internal clocks and half-clock edges come out naturally. It drives an address latch strobe that falls to capture the address, an active-low read strobe, and two active-low write strobes, one for each byte lane. The shared pins are split into an output, an input and an output enable.

Each transfer can be stretched at four points. An address-setup wait lengthens the strobe-high address phase. An address-hold wait lengthens the gap between the latch edge and the data strobe. The data strobe is held low for a programmable number of extra bus clocks, plus more while the external wait pin is held low. A read can end with an idle stretch before the pins carry an address again. The master presents a request and keeps it high until a one-cycle acknowledge. For reads, the returned data comes with that acknowledge.

Top module: `mxb_ctrl`

## Requirements
- R1: During and after reset, with no request, ale_o is 1, rd_n_o, wrlo_n_o and wrhi_n_o are 1, ad_oe_o is 0 and ack_o is 0.
- R2: After a request is accepted, the latched address is driven on ad_o with ad_oe_o=1 and ale_o=1 for exactly 2*(1+S) internal clocks before ale_o falls, where S is cfg_asetup_i (0 or 1).
- R3: From the fall of ale_o to the fall of the data strobe there are exactly 1+2*H internal clocks, where H is cfg_ahold_i (0 or 1), and the address stays driven throughout.
- R4: The data strobe stays low for exactly 2*(1+P+E) internal clocks, where P is cfg_pwait_i and E is the number of extra bus clocks requested through wait_n_i.
- R5: wait_n_i is sampled only at the end of each bus clock of the strobe from bus clock index P onward; a 0 there adds one bus clock, and a 0 at earlier sample points has no effect.
- R6: During a read, ad_oe_o is 0 while rd_n_o is low; ad_i is captured at the edge where rd_n_o rises, and ack_o is 1 for the following internal clock with that value on rdata_o.
- R7: After a read with cfg_rdidle_i=I, ad_oe_o stays 0 for at least 2*(1+I) internal clocks after rd_n_o rises.
- R8: ale_o is 0 while any strobe is low and for exactly one internal clock after the strobe rises, then returns to 1.
- R9: On a write, wdata_i is driven from the clock the write strobe falls until two internal clocks after it rises, after which ad_oe_o is 0.
- R10: be_i selects the write strobes: 2'b01 drives only wrlo_n_o low, 2'b10 only wrhi_n_o, and 2'b11 both. Reads drive only rd_n_o, and read and write strobes are never low together.
- R11: The wait and idle settings, address and write data are captured when the request is accepted; changing them later has no effect on that transfer.
- R12: Each accepted request produces exactly one acknowledge, one internal clock wide, and no new request is accepted until the previous transfer has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request, held until ack_o |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | AW | Transfer address |
| wdata_i | input | 2*LANE_W | Write data |
| be_i | input | 2 | Byte-lane enables for writes |
| cfg_asetup_i | input | 1 | Address-setup wait enable |
| cfg_ahold_i | input | 1 | Address-hold wait enable |
| cfg_pwait_i | input | PW_W | Programmable wait bus clocks |
| cfg_rdidle_i | input | 1 | Idle stretch after reads |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 2*LANE_W | Read data, valid with ack_o |
| ale_o | output | 1 | Address latch strobe, falls to latch |
| rd_n_o | output | 1 | Read strobe, active low |
| wrlo_n_o | output | 1 | Lower byte write strobe, active low |
| wrhi_n_o | output | 1 | Upper byte write strobe, active low |
| ad_o | output | 2*LANE_W | Shared pins, output value |
| ad_i | input | 2*LANE_W | Shared pins, input value |
| ad_oe_o | output | 1 | Shared pins output enable |
| wait_n_i | input | 1 | External wait request, active low |

## Verification
The properties assume a master that keeps req_i and its payload steady until ack_o and drops req_i on the next clock. They also assume that wait_n_i changes synchronously with the internal clock, that write requests carry a nonzero be_i, and that ad_i is stable when the read strobe is released. The bench drives all inputs on the falling clock edge and lowers req_i as soon as it sees the acknowledge. Its external device model drives wait_n_i from the measured strobe length, so the number of added bus clocks is exact, and it presents read data that is fixed from the latch edge onward.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_HOLD,
      ST_STRB,
      ST_REC,
      ST_GAP
   } mxb_state_e;
endpackage

// File: rtl/mxb_seq.sv
module mxb_seq
   import mxb_pkg::*;
#(
   parameter int PW_W        = 3,
   parameter bit EXT_WAIT_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic            we_i,
   input  logic            asetup_i,
   input  logic            ahold_i,
   input  logic [PW_W-1:0] pwait_i,
   input  logic            rdidle_i,
   input  logic            wait_n_i,
   output logic            accept_o,
   output logic            finish_o,
   output logic            we_q_o,
   output mxb_state_e      state_o
);
   localparam int SLOT_W = PW_W + 1;

   mxb_state_e        st;
   logic [1:0]        cnt;
   logic [SLOT_W-1:0] slot;
   logic              half;
   logic              we_q, asetup_q, ahold_q, rdidle_q;
   logic [PW_W-1:0]   pwait_q;
   logic              ext_hold;
   logic              extend;

   generate
      if (EXT_WAIT_EN) begin : g_ext_wait
         assign ext_hold = ~wait_n_i;
      end else begin : g_no_ext_wait
         logic wait_unused;
         assign wait_unused = wait_n_i;
         assign ext_hold    = 1'b0;
      end
   endgenerate

   assign accept_o = (st == ST_IDLE) && req_i;
   assign extend   = (slot < {1'b0, pwait_q}) || ext_hold;
   assign finish_o = (st == ST_STRB) && half && !extend;
   assign we_q_o   = we_q;
   assign state_o  = st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         slot     <= '0;
         half     <= 1'b0;
         we_q     <= 1'b0;
         asetup_q <= 1'b0;
         ahold_q  <= 1'b0;
         rdidle_q <= 1'b0;
         pwait_q  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_i) begin
                  we_q     <= we_i;
                  asetup_q <= asetup_i;
                  ahold_q  <= ahold_i;
                  rdidle_q <= rdidle_i;
                  pwait_q  <= pwait_i;
                  cnt      <= asetup_i ? 2'd3 : 2'd1;
                  st       <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               if (cnt == 2'd0) begin
                  cnt <= ahold_q ? 2'd2 : 2'd0;
                  st  <= ST_HOLD;
               end else begin
                  cnt <= cnt - 2'd1;
               end
            end
            ST_HOLD: begin
               if (cnt == 2'd0) begin
                  slot <= '0;
                  half <= 1'b0;
                  st   <= ST_STRB;
               end else begin
                  cnt <= cnt - 2'd1;
               end
            end
            ST_STRB: begin
               if (!half) begin
                  half <= 1'b1;
               end else begin
                  half <= 1'b0;
                  if (extend) begin
                     if (slot != '1) slot <= slot + 1'b1;
                  end else begin
                     st <= ST_REC;
                  end
               end
            end
            ST_REC: begin
               cnt <= (!we_q && rdidle_q) ? 2'd2 : 2'd0;
               st  <= ST_GAP;
            end
            ST_GAP: begin
               if (cnt == 2'd0) st <= ST_IDLE;
               else             cnt <= cnt - 2'd1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mxb_lanes.sv
module mxb_lanes #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic [LANES-1:0] be_i,
   input  logic             wr_act_i,
   output logic [LANES-1:0] wr_n_o
);
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic be_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        be_q <= 1'b0;
            else if (accept_i) be_q <= be_i[l];
         end
         assign wr_n_o[l] = ~(wr_act_i & be_q);
      end
   endgenerate
endmodule

// File: rtl/mxb_admux.sv
module mxb_admux
   import mxb_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          we_q_i,
   input  mxb_state_e    state_i,
   input  logic          finish_i,
   input  logic [DW-1:0] ad_i,
   output logic [DW-1:0] ad_o,
   output logic          ad_oe_o,
   output logic [DW-1:0] rdata_o,
   output logic          ack_o
);
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic [DW-1:0] addr_ext;
   logic          addr_phase;
   logic          data_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept_i) begin
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
      end
   end

   always_comb begin
      addr_ext         = '0;
      addr_ext[AW-1:0] = addr_q;
   end

   assign addr_phase = (state_i == ST_ADDR) || (state_i == ST_HOLD);
   assign data_phase = we_q_i && ((state_i == ST_STRB) || (state_i == ST_REC) ||
                                  (state_i == ST_GAP));
   assign ad_oe_o    = addr_phase || data_phase;
   assign ad_o       = addr_phase ? addr_ext : wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_o   <= 1'b0;
         rdata_o <= '0;
      end else begin
         ack_o <= finish_i;
         if (finish_i && !we_q_i) rdata_o <= ad_i;
      end
   end
endmodule

// File: rtl/mxb_ctrl.sv
module mxb_ctrl
   import mxb_pkg::*;
#(
   parameter int LANE_W      = 8,
   parameter int AW          = 16,
   parameter int PW_W        = 3,
   parameter bit EXT_WAIT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [2*LANE_W-1:0] wdata_i,
   input  logic [1:0]        be_i,
   input  logic              cfg_asetup_i,
   input  logic              cfg_ahold_i,
   input  logic [PW_W-1:0]   cfg_pwait_i,
   input  logic              cfg_rdidle_i,
   output logic              ack_o,
   output logic [2*LANE_W-1:0] rdata_o,
   output logic              ale_o,
   output logic              rd_n_o,
   output logic              wrlo_n_o,
   output logic              wrhi_n_o,
   output logic [2*LANE_W-1:0] ad_o,
   input  logic [2*LANE_W-1:0] ad_i,
   output logic              ad_oe_o,
   input  logic              wait_n_i
);
   localparam int LANES = 2;
   localparam int DW    = LANES * LANE_W;

   if (LANE_W < 1) begin : g_bad_lane
      $error("mxb_ctrl: LANE_W must be at least 1");
   end
   if (AW < 1 || AW > DW) begin : g_bad_aw
      $error("mxb_ctrl: AW must lie in 1..2*LANE_W");
   end
   if (PW_W < 1 || PW_W > 8) begin : g_bad_pw
      $error("mxb_ctrl: PW_W must lie in 1..8");
   end

   mxb_state_e       state;
   logic             accept, finish, we_q;
   logic [LANES-1:0] wr_n;
   logic             strobe_phase;

   mxb_seq #(
      .PW_W        (PW_W),
      .EXT_WAIT_EN (EXT_WAIT_EN)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .we_i     (we_i),
      .asetup_i (cfg_asetup_i),
      .ahold_i  (cfg_ahold_i),
      .pwait_i  (cfg_pwait_i),
      .rdidle_i (cfg_rdidle_i),
      .wait_n_i (wait_n_i),
      .accept_o (accept),
      .finish_o (finish),
      .we_q_o   (we_q),
      .state_o  (state)
   );

   assign strobe_phase = (state == ST_STRB);

   mxb_lanes #(
      .LANES (LANES)
   ) i_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .be_i     (be_i),
      .wr_act_i (strobe_phase && we_q),
      .wr_n_o   (wr_n)
   );

   mxb_admux #(
      .AW (AW),
      .DW (DW)
   ) i_admux (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .we_q_i   (we_q),
      .state_i  (state),
      .finish_i (finish),
      .ad_i     (ad_i),
      .ad_o     (ad_o),
      .ad_oe_o  (ad_oe_o),
      .rdata_o  (rdata_o),
      .ack_o    (ack_o)
   );

   assign ale_o    = !((state == ST_HOLD) || (state == ST_STRB) || (state == ST_REC));
   assign rd_n_o   = !(strobe_phase && !we_q);
   assign wrlo_n_o = wr_n[0];
   assign wrhi_n_o = wr_n[1];
endmodule

// File: rtl/mxb_ctrl_chk.sv
module mxb_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic ale_o,
   input logic rd_n_o,
   input logic wrlo_n_o,
   input logic wrhi_n_o,
   input logic ad_oe_o,
   input logic ack_o
);
   // R10
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n_o && (!wrlo_n_o || !wrhi_n_o)));

   // R6
   rd_pins_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !ad_oe_o);

   // R8
   ale_low_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n_o || !wrlo_n_o || !wrhi_n_o) |-> !ale_o);

   // R9
   wr_drives_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrlo_n_o || !wrhi_n_o) |-> ad_oe_o);

   // R12
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   // R6
   ack_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (rd_n_o && wrlo_n_o && wrhi_n_o && !ale_o));

   // R3
   addr_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale_o) |-> ad_oe_o);

   // R8
   ale_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale_o) |-> $past(rd_n_o && wrlo_n_o && wrhi_n_o));
endmodule

bind mxb_ctrl mxb_ctrl_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ale_o    (ale_o),
   .rd_n_o   (rd_n_o),
   .wrlo_n_o (wrlo_n_o),
   .wrhi_n_o (wrhi_n_o),
   .ad_oe_o  (ad_oe_o),
   .ack_o    (ack_o)
);

// File: tb/test_mxb_ctrl.sv
module test_mxb_ctrl;
   localparam int LANE_W = 8;
   localparam int DW     = 2 * LANE_W;
   localparam int AW     = 16;
   localparam int PW_W   = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_i, we_i;
   logic [AW-1:0]   addr_i;
   logic [DW-1:0]   wdata_i;
   logic [1:0]      be_i;
   logic            cfg_asetup_i, cfg_ahold_i, cfg_rdidle_i;
   logic [PW_W-1:0] cfg_pwait_i;
   logic            ack_o, ale_o, rd_n_o, wrlo_n_o, wrhi_n_o, ad_oe_o;
   logic [DW-1:0]   rdata_o, ad_o, ad_i;
   logic            wait_n_i;

   always #10 clk = ~clk;

   mxb_ctrl #(
      .LANE_W (LANE_W), .AW (AW), .PW_W (PW_W), .EXT_WAIT_EN (1'b1)
   ) i_mxb_ctrl (
      .clk (clk), .rst_n (rst_n), .req_i (req_i), .we_i (we_i),
      .addr_i (addr_i), .wdata_i (wdata_i), .be_i (be_i),
      .cfg_asetup_i (cfg_asetup_i), .cfg_ahold_i (cfg_ahold_i),
      .cfg_pwait_i (cfg_pwait_i), .cfg_rdidle_i (cfg_rdidle_i),
      .ack_o (ack_o), .rdata_o (rdata_o), .ale_o (ale_o), .rd_n_o (rd_n_o),
      .wrlo_n_o (wrlo_n_o), .wrhi_n_o (wrhi_n_o), .ad_o (ad_o), .ad_i (ad_i),
      .ad_oe_o (ad_oe_o), .wait_n_i (wait_n_i)
   );

   typedef struct {
      bit          we;
      logic [AW-1:0] addr;
      logic [DW-1:0] wdata;
      logic [1:0]  be;
      bit          was, wah, idle;
      int          pw, ext;
   } item_t;

   item_t exp_q[$];
   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                      input logic [1:0] be, input bit was, input bit wah, input bit idle,
                      input int pw, input int ext, input bit scramble);
      item_t it;
      it.we = we; it.addr = addr; it.wdata = wd; it.be = be;
      it.was = was; it.wah = wah; it.idle = idle; it.pw = pw; it.ext = ext;
      exp_q.push_back(it);
      @(negedge clk);
      we_i = we; addr_i = addr; wdata_i = wd; be_i = be;
      cfg_asetup_i = was; cfg_ahold_i = wah; cfg_rdidle_i = idle;
      cfg_pwait_i = PW_W'(pw);
      req_i = 1'b1;
      if (scramble) begin
         do @(negedge clk); while (!(ad_oe_o && ale_o));
         cfg_asetup_i = ~was; cfg_ahold_i = ~wah; cfg_rdidle_i = ~idle;
         cfg_pwait_i = PW_W'(pw) ^ 3'b101;
         addr_i = ~addr; wdata_i = ~wd; be_i = ~be; we_i = ~we;
      end
      do @(negedge clk); while (!ack_o);
      req_i = 1'b0;
   endtask

   // monitor and external device model
   initial begin
      wait_n_i = 1'b1;
      ad_i     = '0;
      @(posedge rst_n);
      forever begin
         item_t         it;
         int            n;
         bit            ok, ok2;
         logic [DW-1:0] a;
         logic [2:0]    pat;
         do @(negedge clk); while (!(ad_oe_o && ale_o));
         n = 0; a = ad_o;
         while (ale_o) begin
            n++; a = ad_o;
            @(negedge clk);
         end
         if (exp_q.size() == 0) begin
            check("R12", "unexpected transfer", 1, 0);
            continue;
         end
         it = exp_q.pop_front();
         check("R2", "setup clocks", n, 2 * (1 + it.was));
         check("R11", "latched address", a, it.addr);
         ad_i = it.addr ^ 16'h5AA5;
         n = 0; ok = 1'b1;
         while (rd_n_o && wrlo_n_o && wrhi_n_o) begin
            n++;
            if (!(ad_oe_o && ad_o == it.addr)) ok = 1'b0;
            @(negedge clk);
         end
         check("R3", "hold clocks", n, 1 + 2 * it.wah);
         check("R3", "address held", ok, 1);
         pat = {rd_n_o, wrhi_n_o, wrlo_n_o};
         n = 0; ok = 1'b1; ok2 = 1'b1;
         while (!(rd_n_o && wrlo_n_o && wrhi_n_o)) begin
            n++;
            if (it.we) begin
               if (!(ad_oe_o && ad_o == it.wdata)) ok = 1'b0;
            end else if (ad_oe_o) ok = 1'b0;
            if (ale_o) ok2 = 1'b0;
            wait_n_i = !(n < 2 * (it.pw + it.ext) + 2);
            @(negedge clk);
         end
         wait_n_i = 1'b1;
         // R4 and R5: width includes programmable and external waits only
         check("R4", "strobe low clocks", n, 2 * (1 + it.pw + it.ext));
         check(it.we ? "R9" : "R6", "pins during strobe", ok, 1);
         check("R8", "latch low in strobe", ok2, 1);
         check("R10", "strobe pattern", pat,
               it.we ? {1'b1, ~it.be[1], ~it.be[0]} : 3'b011);
         check("R12", "ack after release", ack_o, 1);
         check("R8", "latch low one clock", ale_o, 0);
         if (it.we) check("R9", "data held 1", {ad_oe_o, ad_o}, {1'b1, it.wdata});
         else       check("R6", "read data", rdata_o, it.addr ^ 16'h5AA5);
         @(negedge clk);
         check("R8", "latch back high", ale_o, 1);
         check("R12", "ack one clock", ack_o, 0);
         if (it.we) begin
            check("R9", "data held 2", {ad_oe_o, ad_o}, {1'b1, it.wdata});
            @(negedge clk);
            check("R9", "pins released", ad_oe_o, 0);
         end else begin
            check("R7", "pins free after read", ad_oe_o, 0);
            for (int k = 3; k <= 2 * (1 + it.idle); k++) begin
               @(negedge clk);
               check("R7", "idle stretch", ad_oe_o, 0);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R12 watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0; be_i = 2'b00;
      cfg_asetup_i = 1'b0; cfg_ahold_i = 1'b0; cfg_rdidle_i = 1'b0; cfg_pwait_i = '0;
      repeat (3) @(negedge clk);
      check("R1", "reset pins", {ale_o, rd_n_o, wrlo_n_o, wrhi_n_o, ad_oe_o, ack_o},
            6'b111100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "idle pins", {ale_o, rd_n_o, wrlo_n_o, wrhi_n_o, ad_oe_o, ack_o},
            6'b111100);
      // plain read, no waits
      run(1'b0, 16'h1234, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
      // 16-bit write, R10 both lanes
      run(1'b1, 16'h2002, 16'hBEEF, 2'b11, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
      // lower lane only, upper lane only
      run(1'b1, 16'h3004, 16'h00A1, 2'b01, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
      run(1'b1, 16'h3005, 16'hB200, 2'b10, 1'b0, 1'b1, 1'b0, 1, 0, 1'b0);
      // read with setup, hold and idle stretch (R2, R3, R7)
      run(1'b0, 16'h4444, 16'h0000, 2'b00, 1'b1, 1'b1, 1'b1, 0, 0, 1'b0);
      // R5: programmable waits, wait pin low early is ignored
      run(1'b0, 16'h5A00, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b0, 2, 0, 1'b0);
      // R5: external waits only
      run(1'b0, 16'h6001, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b1, 0, 2, 1'b0);
      // R5: both kinds on a write
      run(1'b1, 16'h7FFE, 16'h1357, 2'b11, 1'b1, 1'b0, 1'b0, 3, 1, 1'b0);
      // R11: inputs changed after acceptance
      run(1'b0, 16'h8123, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b1, 1, 0, 1'b1);
      run(1'b1, 16'h9ABC, 16'hC0DE, 2'b01, 1'b1, 1'b0, 1'b0, 2, 1, 1'b1);
      // back-to-back reads at the longest programmable wait
      run(1'b0, 16'hA0A0, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b0, 7, 0, 1'b0);
      run(1'b0, 16'hFFFF, 16'h0000, 2'b00, 1'b1, 1'b1, 1'b0, 0, 3, 1'b0);
      repeat (12) @(negedge clk);
      check("R12", "all transfers seen", exp_q.size(), 0);
      check("R1", "back to idle", {ale_o, rd_n_o, wrlo_n_o, wrhi_n_o, ad_oe_o, ack_o},
            6'b111100);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule